// File: doc/BRIEF.md
# Block Memory Transfer Sequencer

This sequencer copies a run of bytes from one address range to another over a single synchronous byte memory port. A one-cycle start pulse supplies a source address, a destination address, a byte count, a mode code, the current stack pointer and three register values to preserve. The sequencer first saves the three registers on a stack held in a fixed page of memory. It then moves the bytes, each with one read followed by one write, and restores the registers before it signals completion.

Five address patterns are offered. Both addresses can step up, or both can step down. The source alone can step up while the destination stays fixed. Two alternating patterns add an offset of 0 or 1 that flips every byte: one applies it to a fixed destination while the source steps up, the other applies it to a fixed source while the destination steps up. The byte count is tested only after it has been decremented, so a count of zero moves the full range of the count register.

The memory port returns read data one cycle after the read strobe. Every transfer takes a fixed 17 cycles of overhead plus 6 cycles per byte.

Top module: `blkmove_seq`

## Requirements
- R1: After reset and whenever idle, `busy`, `done`, `mem_re` and `mem_we` are low.
- R2: In the first three busy cycles the saved Y, A and X values are written, in that order, to stack addresses {STK_PAGE, sp}, {STK_PAGE, sp-1} and {STK_PAGE, sp-2}, where sp is `sp_in` captured at start.
- R3: Each byte occupies a 6-cycle slot. The slot's first cycle reads from the source. Its second cycle writes the data the memory returned to the destination. The remaining four cycles make no memory access.
- R4: Mode 0 (and any unlisted code 5 to 7) reads from the source and writes to the destination, then increments both addresses by one.
- R5: Mode 1 decrements both source and destination by one after every byte.
- R6: Mode 2 increments only the source. Every write goes to the same destination address.
- R7: Mode 3 increments the source every byte. The write goes to destination plus an offset that starts at 0 and toggles between 0 and 1 every byte, while the destination base stays fixed.
- R8: Mode 4 reads from source plus an offset that starts at 0 and toggles every byte, while the source base stays fixed. The destination increments every byte.
- R9: All address arithmetic wraps modulo 65536.
- R10: A starting count of 0 moves 2^LW bytes, with LW the count width.
- R11: `busy` stays high for exactly 17 + 6·N cycles for N bytes. `done` is high for a single cycle, which is the last busy cycle and follows the final pop.
- R12: After the last byte, three pops read {STK_PAGE, sp-2}, {STK_PAGE, sp-1} and {STK_PAGE, sp} (X, A, Y). `sp_out` then equals the starting stack pointer.
- R13: A start pulse while busy has no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| mode | input | 3 | Address pattern code (0 to 4) |
| src_in | input | AW | Source start address |
| dst_in | input | AW | Destination start address |
| len_in | input | LW | Byte count, 0 meaning 2^LW |
| sp_in | input | 8 | Stack pointer at start |
| reg_y | input | DW | Y value to save |
| reg_a | input | DW | A value to save |
| reg_x | input | DW | X value to save |
| mem_addr | output | AW | Memory address |
| mem_re | output | 1 | Read strobe, data returned next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 8 | Current stack pointer |

## Verification
Some properties are checked on every cycle: no memory strobe while idle, reads and writes never overlap, a move read is always followed by its write, pops stay inside the stack page, `done` is a single pulse that ends busy, and a start while busy never drops busy. Other behaviour can only be shown by the bench's scenarios against its reference model. This covers the address sequence of each mode, the alternating offsets, wrap at the top and bottom of the address space, the zero-count full-range case, the exact cycle count, and the preserved stack pointer.

// File: rtl/blkmove_seq.sv
module blkmove_seq #(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int DW = 8,
  parameter logic [AW-9:0] STK_PAGE = 'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [LW-1:0] len_in,
  input  logic [7:0]    sp_in,
  input  logic [DW-1:0] reg_y,
  input  logic [DW-1:0] reg_a,
  input  logic [DW-1:0] reg_x,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [7:0]    sp_out
);
  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_PRE, S_MOVE, S_POST, S_POP, S_FIN} st_t;

  st_t           st;
  logic [2:0]    cnt;
  logic [2:0]    md;
  logic [AW-1:0] src, dst;
  logic [LW-1:0] len;
  logic          alt;
  logic [7:0]    sp;
  logic [DW-1:0] sv_y, sv_a, sv_x;

  wire m_dec  = (md == 3'd1);
  wire m_fix  = (md == 3'd2);
  wire m_altd = (md == 3'd3);
  wire m_alts = (md == 3'd4);

  wire [AW-1:0] rd_addr = src + {{(AW-1){1'b0}}, alt & m_alts};
  wire [AW-1:0] wr_addr = dst + {{(AW-1){1'b0}}, alt & m_altd};
  wire [AW-1:0] src_nx  = m_dec ? src - 1'b1 : (m_alts ? src : src + 1'b1);
  wire [AW-1:0] dst_nx  = m_dec ? dst - 1'b1 : ((m_fix | m_altd) ? dst : dst + 1'b1);
  wire [7:0]    sp_up   = sp + 8'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; md <= '0; src <= '0; dst <= '0; len <= '0;
      alt <= 1'b0; sp <= '0; sv_y <= '0; sv_a <= '0; sv_x <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_PUSH; cnt <= '0; md <= mode; src <= src_in; dst <= dst_in;
          len <= len_in; alt <= 1'b0; sp <= sp_in;
          sv_y <= reg_y; sv_a <= reg_a; sv_x <= reg_x;
        end
        S_PUSH: begin
          sp <= sp - 8'd1;
          if (cnt == 3'd2) begin st <= S_PRE; cnt <= '0; end
          else cnt <= cnt + 3'd1;
        end
        S_PRE:
          if (cnt == 3'd5) begin st <= S_MOVE; cnt <= '0; end
          else cnt <= cnt + 3'd1;
        S_MOVE: begin
          if (cnt == 3'd1) begin
            src <= src_nx; dst <= dst_nx; alt <= ~alt; len <= len - 1'b1;
          end
          if (cnt == 3'd5) begin
            cnt <= '0;
            if (len == '0) st <= S_POST;
          end else cnt <= cnt + 3'd1;
        end
        S_POST:
          if (cnt == 3'd3) begin st <= S_POP; cnt <= '0; end
          else cnt <= cnt + 3'd1;
        S_POP: begin
          sp <= sp_up;
          if (cnt == 3'd2) begin st <= S_FIN; cnt <= '0; end
          else cnt <= cnt + 3'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign done   = (st == S_FIN);
  assign sp_out = sp;
  assign mem_we = (st == S_PUSH) || (st == S_MOVE && cnt == 3'd1);
  assign mem_re = (st == S_POP)  || (st == S_MOVE && cnt == 3'd0);

  always_comb begin
    mem_addr  = wr_addr;
    mem_wdata = mem_rdata;
    if (st == S_PUSH) begin
      mem_addr  = {STK_PAGE, sp};
      mem_wdata = (cnt == 3'd0) ? sv_y : ((cnt == 3'd1) ? sv_a : sv_x);
    end else if (st == S_POP) begin
      mem_addr = {STK_PAGE, sp_up};
    end else if (st == S_MOVE && cnt == 3'd0) begin
      mem_addr = rd_addr;
    end
  end

  // R1
  mem_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_re || mem_we));
  // R3
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MOVE && mem_re) |=> (mem_we && !mem_re));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R12
  pop_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POP) |-> (mem_addr[AW-1:8] == STK_PAGE));
  // R13
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
endmodule

// File: tb/tb_blkmove_seq.sv
module tb_blkmove_seq;
  localparam int LW = 8;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] src_in = '0, dst_in = '0;
  logic [LW-1:0] len_in = '0;
  logic [7:0]  sp_in = '0, reg_y = '0, reg_a = '0, reg_x = '0;
  logic [15:0] mem_addr;
  logic        mem_re, mem_we, busy, done;
  logic [7:0]  mem_wdata, mem_rdata = '0, sp_out;

  blkmove_seq #(.AW(16), .LW(LW), .DW(8), .STK_PAGE(8'h01)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .src_in(src_in),
    .dst_in(dst_in), .len_in(len_in), .sp_in(sp_in), .reg_y(reg_y),
    .reg_a(reg_a), .reg_x(reg_x), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .sp_out(sp_out));

  always #2 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= memf(mem_addr);

  typedef struct packed {
    logic re, we, bz, dn;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [23:0] tag;
  } rec_t;

  rec_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit chk_en = 1'b0, finished = 1'b0;

  function automatic rec_t mk(logic re, logic we, logic bz, logic dn,
                              logic [15:0] a, logic [7:0] wd, logic [23:0] tag);
    rec_t r;
    r.re = re; r.we = we; r.bz = bz; r.dn = dn; r.addr = a; r.wd = wd; r.tag = tag;
    return r;
  endfunction

  always @(negedge clk) if (chk_en && !finished) begin
    rec_t e;
    bit bad;
    if (exp_q.size() > 0) e = exp_q.pop_front();
    else e = mk(0, 0, 0, 0, 16'h0, 8'h0, "R1");
    bad = (busy !== e.bz) || (done !== e.dn) || (mem_re !== e.re) || (mem_we !== e.we);
    if ((e.re || e.we) && mem_addr !== e.addr) bad = 1;
    if (e.we && mem_wdata !== e.wd) bad = 1;
    n_cmp++;
    if (bad) begin
      n_bad++;
      $display("FAIL %0s: got bz=%0b dn=%0b re=%0b we=%0b a=%h wd=%h exp bz=%0b dn=%0b re=%0b we=%0b a=%h wd=%h",
        e.tag, busy, done, mem_re, mem_we, mem_addr, mem_wdata,
        e.bz, e.dn, e.re, e.we, e.addr, e.wd);
    end
  end

  task automatic idle_n(int n, logic [23:0] tag);
    for (int i = 0; i < n; i++) exp_q.push_back(mk(0, 0, 1, 0, 16'h0, 8'h0, tag));
  endtask

  task automatic run(int md, int s0, int d0, int ln, int sp0, logic [23:0] mtag, int poke);
    int s, d, alt, nb, ra, wa;
    @(posedge clk); #1;
    mode = md[2:0]; src_in = s0[15:0]; dst_in = d0[15:0]; len_in = ln[LW-1:0];
    sp_in = sp0[7:0]; reg_y = 8'hA1 ^ sp0[7:0]; reg_a = 8'hB2; reg_x = 8'hC3 ^ md[7:0];
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    // R2 pushes
    exp_q.push_back(mk(0, 1, 1, 0, {8'h01, sp0[7:0]}, reg_y, "R2"));
    exp_q.push_back(mk(0, 1, 1, 0, {8'h01, 8'(sp0 - 1)}, reg_a, "R2"));
    exp_q.push_back(mk(0, 1, 1, 0, {8'h01, 8'(sp0 - 2)}, reg_x, "R2"));
    idle_n(6, "R11");
    s = s0; d = d0; alt = 0;
    nb = (ln == 0) ? (1 << LW) : ln;
    for (int k = 0; k < nb; k++) begin
      ra = (md == 4) ? ((s + alt) & 16'hFFFF) : s;
      wa = (md == 3) ? ((d + alt) & 16'hFFFF) : d;
      exp_q.push_back(mk(1, 0, 1, 0, ra[15:0], 8'h0, mtag));
      exp_q.push_back(mk(0, 1, 1, 0, wa[15:0], memf(ra[15:0]), "R3"));
      idle_n(4, "R3");
      case (md)
        1: begin s = s - 1; d = d - 1; end
        2: s = s + 1;
        3: s = s + 1;
        4: d = d + 1;
        default: begin s = s + 1; d = d + 1; end
      endcase
      s = s & 16'hFFFF; d = d & 16'hFFFF; alt ^= 1;
    end
    idle_n(4, "R11");
    exp_q.push_back(mk(1, 0, 1, 0, {8'h01, 8'(sp0 - 2)}, 8'h0, "R12"));
    exp_q.push_back(mk(1, 0, 1, 0, {8'h01, 8'(sp0 - 1)}, 8'h0, "R12"));
    exp_q.push_back(mk(1, 0, 1, 0, {8'h01, sp0[7:0]}, 8'h0, "R12"));
    exp_q.push_back(mk(0, 0, 1, 1, 16'h0, 8'h0, "R11"));
    if (poke > 0) begin
      // R13: a second start mid-transfer with different operands
      repeat (poke) @(posedge clk);
      #1;
      mode = 3'd1; src_in = 16'h7777; dst_in = 16'h8888; len_in = 8'd2; sp_in = 8'h10;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    wait (exp_q.size() == 0);
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (sp_out !== sp0[7:0]) begin
      n_bad++;
      $display("FAIL R12: sp_out got %h exp %h", sp_out, sp0[7:0]);
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_en = 1'b1;                          // R1 idle after reset
    repeat (4) @(posedge clk);
    run(0, 16'h1000, 16'h2000, 5, 8'hFF, "R4", 0);
    run(1, 16'h3010, 16'h4010, 4, 8'h80, "R5", 0);
    run(2, 16'h0500, 16'h0A00, 4, 8'h40, "R6", 0);
    run(3, 16'h1234, 16'h5670, 5, 8'h22, "R7", 0);
    run(4, 16'h2468, 16'h9000, 5, 8'h33, "R8", 0);
    run(6, 16'h0100, 16'h0200, 3, 8'h44, "R4", 0);
    run(0, 16'hFFFE, 16'hFFFF, 4, 8'h02, "R9", 0);
    run(1, 16'h0001, 16'h0000, 3, 8'h01, "R9", 0);
    run(3, 16'hC000, 16'hD000, 0, 8'h90, "R10", 0);
    run(0, 16'h6000, 16'h6100, 6, 8'h55, "R13", 12);
    repeat (5) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule